// File: doc/BRIEF.md
# Floating-Point Control Register Unit

This block keeps the floating-point control and status word of a 64-bit processor. It accumulates sticky exception flags reported by the floating-point unit, holds five per-exception trap-disable bits, and holds a dynamic rounding-mode field. The rounding mode goes to the floating-point unit in that unit's own encoding. The trap-disable bits go out as a trap mask.

Software reads the control word through a 64-bit combinational read port and loads it through a 64-bit write port. Each read strobe also mirrors the current flags into a separate exception-summary register image. In that image the flags sit one bit higher than in the flag field.

Top module: `fp_ctl_reg`

## Requirements
- R1: After reset, the flags and disable bits are zero. The rounding field reads 2 and `fpu_rnd` is 2'b00 (nearest even). `exc_sum` is zero.
- R2: A write loads the six flag bits at `rd_data[57:52]` from `wr_data[57:52]`.
- R3: When no write occurs, `fpu_evt[k]` is ORed into flag bit 52+k on each clock, for k = 0 to 4. Flags never clear on their own. Flag bit 57 changes only by a write.
- R4: When a write and `fpu_evt` pulses arrive in the same cycle, the written flag value is kept and the pulses are dropped.
- R5: `rd_data[63]` is 1 exactly when any of `rd_data[57:52]` is 1.
- R6: On a clock with `rd_en` high, `exc_sum[5:1]` takes the flag bits 52..56 that were readable in that cycle. `exc_sum[6]` is ORed with flag bit 57. All other bits of `exc_sum` stay zero. Without `rd_en`, `exc_sum` holds its value.
- R7: The disable bits sit at these positions: invalid at 49, divide-by-zero at 50, overflow at 51, underflow at 61 and inexact at 62. A write loads them, a read returns them, and `trap_mask[4:0]` presents them in the order {inexact, underflow, overflow, divide-by-zero, invalid}.
- R8: The rounding field `rd_data[59:58]` is loaded by a write and reads back unchanged. Field value 0 means toward zero, 1 toward minus infinity, 2 nearest even and 3 toward plus infinity. `fpu_rnd` encodes the same modes as 2'b11, 2'b01, 2'b00 and 2'b10 respectively.
- R9: Bits 48:0 and 60 of `rd_data` always read zero, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | Value to write |
| rd_en | input | 1 | Read strobe; updates the summary image |
| rd_data | output | 64 | Current control word |
| fpu_evt | input | 5 | Exception pulses from the FPU |
| trap_mask | output | 5 | Trap-disable bits for the FPU |
| fpu_rnd | output | 2 | Rounding mode in FPU encoding |
| exc_sum | output | 64 | Exception-summary register image |

## Verification
The hardest situation to reach is bit 6 of the summary image. That bit is only ever ORed and never cleared, so it differs from the cleared-and-reloaded bits 5:1 only after a later read with a cleaner flag set. The stimulus first writes flag bit 57, issues a read, then writes all flags to zero and reads again. It expects bits 5:1 to clear while bit 6 stays set. A same-cycle write with FPU pulses, and a read while pulses arrive, cover the ordering cases.

// File: rtl/fp_ctl_reg.sv
module fp_ctl_reg #(
  parameter int XLEN     = 64,
  parameter int FLAG_LSB = 52,
  parameter int FLAG_W   = 6,
  parameter int EVT_W    = 5,
  parameter int SUM_BIT  = 63,
  parameter int RND_LSB  = 58,
  parameter int DIS_INV  = 49,
  parameter int DIS_DZE  = 50,
  parameter int DIS_OVF  = 51,
  parameter int DIS_UNF  = 61,
  parameter int DIS_INE  = 62,
  parameter int SUMREG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            rd_en,
  output logic [XLEN-1:0] rd_data,
  input  logic [EVT_W-1:0] fpu_evt,
  output logic [4:0]      trap_mask,
  output logic [1:0]      fpu_rnd,
  output logic [XLEN-1:0] exc_sum
);

  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_DOWN = 2'b01;
  localparam logic [1:0] RM_UP   = 2'b10;
  localparam logic [1:0] RM_ZERO = 2'b11;
  localparam logic [SUMREG_W-1:0] SUM_CLR = SUMREG_W'({EVT_W{1'b1}}) << 1;

  logic [FLAG_W-1:0]   flags;
  logic [SUMREG_W-1:0] sum_q;
  logic [1:0]          rnd_field;

  always_ff @(posedge clk) begin
    if (!rst_n)     flags <= '0;
    else if (wr_en) flags <= wr_data[FLAG_LSB +: FLAG_W];
    else            flags <= flags | FLAG_W'(fpu_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_mask <= '0;
      fpu_rnd   <= RM_NEAR;
    end else if (wr_en) begin
      trap_mask <= {wr_data[DIS_INE], wr_data[DIS_UNF], wr_data[DIS_OVF],
                    wr_data[DIS_DZE], wr_data[DIS_INV]};
      case (wr_data[RND_LSB +: 2])
        2'd0:    fpu_rnd <= RM_ZERO;
        2'd1:    fpu_rnd <= RM_DOWN;
        2'd2:    fpu_rnd <= RM_NEAR;
        default: fpu_rnd <= RM_UP;
      endcase
    end
  end

  always_comb begin
    case (fpu_rnd)
      RM_NEAR: rnd_field = 2'd2;
      RM_DOWN: rnd_field = 2'd1;
      RM_UP:   rnd_field = 2'd3;
      default: rnd_field = 2'd0;
    endcase
  end

  always_comb begin
    rd_data = '0;
    rd_data[FLAG_LSB +: FLAG_W] = flags;
    rd_data[SUM_BIT]            = |flags;
    rd_data[RND_LSB +: 2]       = rnd_field;
    rd_data[DIS_INV]            = trap_mask[0];
    rd_data[DIS_DZE]            = trap_mask[1];
    rd_data[DIS_OVF]            = trap_mask[2];
    rd_data[DIS_UNF]            = trap_mask[3];
    rd_data[DIS_INE]            = trap_mask[4];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sum_q <= '0;
    else if (rd_en) sum_q <= (sum_q & ~SUM_CLR) | (SUMREG_W'(flags) << 1);
  end

  assign exc_sum = XLEN'(sum_q);

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[FLAG_LSB +: FLAG_W] == $past(wr_data[FLAG_LSB +: FLAG_W]));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> rd_data[FLAG_LSB +: FLAG_W] ==
               ($past(rd_data[FLAG_LSB +: FLAG_W]) | FLAG_W'($past(fpu_evt))));

  assert_sum_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> exc_sum[EVT_W:1] == $past(rd_data[FLAG_LSB +: EVT_W]));

  assert_sum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(exc_sum));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(trap_mask) && $stable(fpu_rnd));

endmodule

// File: tb/tb_fp_ctl_reg.sv
module tb_fp_ctl_reg;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [63:0] wr_data = '0, rd_data, exc_sum;
  logic [4:0] fpu_evt = '0, trap_mask;
  logic [1:0] fpu_rnd;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  fp_ctl_reg dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                  .rd_en(rd_en), .rd_data(rd_data), .fpu_evt(fpu_evt),
                  .trap_mask(trap_mask), .fpu_rnd(fpu_rnd), .exc_sum(exc_sum));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [63:0] wd, input logic r, input logic [4:0] ev);
    @(negedge clk);
    wr_en = w; wr_data = wd; rd_en = r; fpu_evt = ev;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; fpu_evt = '0;
  endtask

  function automatic logic [63:0] word(input logic [5:0] fl, input logic [4:0] dis, input logic [1:0] rf);
    logic [63:0] v = '0;
    v[57:52] = fl; v[63] = |fl; v[59:58] = rf;
    v[49] = dis[0]; v[50] = dis[1]; v[51] = dis[2]; v[61] = dis[3]; v[62] = dis[4];
    return v;
  endfunction

  function automatic logic [63:0] wval(input logic [5:0] fl, input logic [4:0] dis, input logic [1:0] rf);
    logic [63:0] v = '0;
    v[57:52] = fl; v[59:58] = rf;
    v[49] = dis[0]; v[50] = dis[1]; v[51] = dis[2]; v[61] = dis[3]; v[62] = dis[4];
    return v;
  endfunction

  task automatic t_reset;
    chk("R1 rd_data", rd_data, word(6'h0, 5'h0, 2'd2));
    chk("R1 fpu_rnd", {62'd0, fpu_rnd}, 64'd0);
    chk("R1 exc_sum", exc_sum, 64'd0);
    chk("R1 trap_mask", {59'd0, trap_mask}, 64'd0);
  endtask

  task automatic t_write;
    step(1, wval(6'h15, 5'h0A, 2'd2), 0, 0);
    chk("R2 flags load", rd_data, word(6'h15, 5'h0A, 2'd2));
    chk("R5 summary bit set", {63'd0, rd_data[63]}, 64'd1);
    chk("R7 trap_mask", {59'd0, trap_mask}, 64'h0A);
    step(1, wval(6'h00, 5'h15, 2'd2), 0, 0);
    chk("R5 summary bit clear", {63'd0, rd_data[63]}, 64'd0);
    chk("R7 read dis", rd_data, word(6'h0, 5'h15, 2'd2));
    chk("R7 trap_mask 15", {59'd0, trap_mask}, 64'h15);
  endtask

  task automatic t_sticky;
    step(1, wval(6'h0, 5'h0, 2'd2), 0, 0);
    step(0, 64'd0, 0, 5'h01);
    chk("R3 evt0", {58'd0, rd_data[57:52]}, 64'h01);
    step(0, 64'd0, 0, 5'h10);
    step(0, 64'd0, 0, 5'h00);
    chk("R3 sticky accumulate", {58'd0, rd_data[57:52]}, 64'h11);
    step(0, 64'd0, 0, 5'h1F);
    chk("R3 all pulses, bit57 untouched", {58'd0, rd_data[57:52]}, 64'h1F);
  endtask

  task automatic t_priority;
    step(1, wval(6'h20, 5'h0, 2'd2), 0, 5'h1F);
    chk("R4 write beats pulses", {58'd0, rd_data[57:52]}, 64'h20);
  endtask

  task automatic t_summary;
    step(1, wval(6'h2A, 5'h0, 2'd2), 0, 0);
    step(0, 64'd0, 0, 0);
    chk("R6 hold without read", exc_sum, 64'd0);
    step(0, 64'd0, 1, 5'h01);
    chk("R6 read mirror (pre-pulse flags)", exc_sum, 64'h54);
    step(1, wval(6'h00, 5'h0, 2'd2), 0, 0);
    step(0, 64'd0, 1, 0);
    chk("R6 bits5:1 cleared, bit6 kept", exc_sum, 64'h40);
    step(0, 64'd0, 0, 5'h06);
    step(0, 64'd0, 1, 0);
    chk("R6 reload", exc_sum, 64'h4C);
  endtask

  task automatic t_round;
    logic [1:0] enc [4] = '{2'b11, 2'b01, 2'b00, 2'b10};
    for (int i = 0; i < 4; i++) begin
      step(1, wval(6'h0, 5'h0, 2'(i)), 0, 0);
      chk("R8 field readback", {62'd0, rd_data[59:58]}, 64'(i));
      chk("R8 fpu_rnd", {62'd0, fpu_rnd}, {62'd0, enc[i]});
    end
  endtask

  task automatic t_reserved;
    step(1, {64{1'b1}}, 0, 0);
    chk("R9 unused bits zero", rd_data, word(6'h3F, 5'h1F, 2'd3));
    chk("R9 low bits", {15'd0, rd_data[48:0]}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write;
    t_sticky;
    t_priority;
    t_summary;
    t_round;
    t_reserved;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule